// File: doc/BRIEF.md
# Programmable Servo Gate Sequencer

This block runs short microprograms that time the servo gate, the acquisition (start-up) flag and an interrupt line for a disk servo channel. A host loads up to 32 command words into a small control store while the sequencer is idle. It then raises the run control. From that point the sequencer steps through the store on servo clock ticks. Each command sets the three outputs and holds them for a programmed number of ticks. It then moves on to the next entry or to a branch target.

A branch depends on a tested condition: a sync mark seen during the hold, a head-switch request latched earlier, an external event at the end of the hold, or an unconditional jump. With these tests, one store can hold acquisition, tracking, recovery and head-switch routines that pass control among each other. The address of the active entry is brought out so that integration and debug can follow the program flow.

Top module: `svo_gate_seq`

## Requirements
- R1: After reset the sequencer is idle, all three outputs are low and the active address reads 0.
- R2: A 32-bit command holds the tick count in bits [31:16], the branch target in bits [15:11], the condition code in bits [10:8] and the action byte in bits [7:0]. In the action byte, bit 1 drives the gate, bit 0 drives the acquisition flag and bit 4 drives the interrupt; the other bits have no effect.
- R3: While the sequencer is idle and run is high, the first clock edge with the tick enable high loads entry 0. That same edge sets the outputs from the action byte of entry 0.
- R4: A loaded command with count N≥1 stays active for exactly N further clock edges on which the tick enable is high. Edges with the tick enable low change nothing at the outputs.
- R5: A count of 0 is held for one tick, the same as a count of 1.
- R6: Condition codes 4, 0, 6 and 7 fall through to address+1 when the count expires. The address wraps from 31 to 0.
- R7: Condition code 5 jumps to the target when the count expires.
- R8: Condition code 3 branches to the target on the first tick edge after the load at which the sync input is high, even before the count expires. If no sync is seen, the command falls through when the count expires.
- R9: A head-switch request pulse is latched while the sequencer runs. A command with condition code 2 branches to the target at expiry if the latch is set or the request is high at that edge, and otherwise falls through. The latch clears at the expiry of every condition-code-2 command and whenever the sequencer is idle.
- R10: Condition code 1 branches to the target at expiry if the event input is high at that edge, and otherwise falls through.
- R11: Run low at a clock edge returns the sequencer to idle at that edge. The outputs go low and the address goes to 0.
- R12: Store writes are accepted only while the sequencer is idle. Writes made while it runs leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 5 | Store entry to write |
| wr_data | input | 32 | Command word to write |
| run | input | 1 | High to run the program, low to stop |
| sclk_en | input | 1 | Servo clock tick enable |
| sync_found | input | 1 | Sync mark seen by the channel |
| hsw_req | input | 1 | Head-switch request pulse |
| ext_event | input | 1 | External event level |
| gate_o | output | 1 | Servo gate |
| acq_o | output | 1 | Acquisition (start-up) flag |
| irq_o | output | 1 | Interrupt request |
| addr_o | output | 5 | Address of the active command |

## Verification
Every result is registered once. A start, a load, a branch or a stop driven in one clock cycle shows at the outputs after the next rising edge and not before. The bench drives inputs on the falling edge and samples one falling edge later, which is half a cycle after the edge that acts on them. A reference model in the bench advances on the same edges from the same inputs. Each sample is compared with that model. Directed steps also check fixed values at the points where a count expires, a sync arrives, or a latched request or event is tested.

// File: rtl/svseq_pkg.sv
package svseq_pkg;

    localparam int SEQ_AW    = 5;
    localparam int SEQ_DEPTH = 1 << SEQ_AW;
    localparam int CNT_W     = 16;
    localparam int CND_W     = 3;
    localparam int ACT_W     = 8;
    localparam int WORD_W    = CNT_W + SEQ_AW + CND_W + ACT_W;

    localparam int ACT_ACQ_BIT  = 0;
    localparam int ACT_GATE_BIT = 1;
    localparam int ACT_IRQ_BIT  = 4;

    typedef enum logic [CND_W-1:0] {
        CND_NONE0 = 3'd0,
        CND_EVENT = 3'd1,
        CND_HSW   = 3'd2,
        CND_SYNC  = 3'd3,
        CND_NEXT  = 3'd4,
        CND_JUMP  = 3'd5,
        CND_RSV6  = 3'd6,
        CND_RSV7  = 3'd7
    } seq_cnd_e;

    typedef struct packed {
        logic [CNT_W-1:0]  hold;
        logic [SEQ_AW-1:0] tgt;
        logic [CND_W-1:0]  cnd;
        logic [ACT_W-1:0]  act;
    } seq_cmd_t;

    typedef struct packed {
        logic              running;
        logic [SEQ_AW-1:0] pc;
        logic [CNT_W-1:0]  cnt;
        logic [SEQ_AW-1:0] tgt;
        logic [CND_W-1:0]  cnd;
        logic              hsw;
        logic              gate;
        logic              acq;
        logic              irq;
    } seq_state_t;

    localparam seq_state_t SEQ_IDLE = '0;

    function automatic logic [CNT_W-1:0] hold_len(input logic [CNT_W-1:0] h);
        return (h == '0) ? CNT_W'(1) : h;
    endfunction

endpackage

// File: rtl/svseq_store.sv
module svseq_store
    import svseq_pkg::*;
#(
    parameter int DEPTH = SEQ_DEPTH,
    parameter int DW    = WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/svseq_branch.sv
module svseq_branch
    import svseq_pkg::*;
(
    input  logic [SEQ_AW-1:0] pc,
    input  logic [SEQ_AW-1:0] tgt,
    input  logic [CND_W-1:0]  cnd,
    input  logic              tick,
    input  logic              cnt_last,
    input  logic              sync_found,
    input  logic              hsw_pend,
    input  logic              ext_event,
    output logic              load,
    output logic [SEQ_AW-1:0] nxt_pc,
    output logic              hsw_consume
);

    logic expire;
    logic take;

    assign expire = tick && cnt_last;

    always_comb begin
        take        = 1'b0;
        load        = expire;
        hsw_consume = 1'b0;
        unique case (seq_cnd_e'(cnd))
            CND_SYNC: begin
                take = tick && sync_found;
                load = expire || take;
            end
            CND_JUMP:  take = 1'b1;
            CND_HSW: begin
                take        = hsw_pend;
                hsw_consume = expire;
            end
            CND_EVENT: take = ext_event;
            default:   take = 1'b0;
        endcase
        nxt_pc = take ? tgt : pc + SEQ_AW'(1);
    end

endmodule

// File: rtl/svo_gate_seq.sv
module svo_gate_seq
    import svseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEQ_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              run,
    input  logic              sclk_en,
    input  logic              sync_found,
    input  logic              hsw_req,
    input  logic              ext_event,
    output logic              gate_o,
    output logic              acq_o,
    output logic              irq_o,
    output logic [SEQ_AW-1:0] addr_o
);

    seq_state_t        st_q, st_d;
    logic [WORD_W-1:0] rd_word;
    seq_cmd_t          rd_cmd;
    logic [SEQ_AW-1:0] rd_addr;
    logic              br_load;
    logic [SEQ_AW-1:0] br_nxt;
    logic              br_consume;
    logic              store_we;

    logic              running_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CND_W-1:0]  cond_w;
    logic [SEQ_AW-1:0] tgt_w;

    assign store_we = wr_en && !st_q.running;
    assign rd_addr  = st_q.running ? br_nxt : '0;
    assign rd_cmd   = seq_cmd_t'(rd_word);

    svseq_store #(
        .DEPTH (SEQ_DEPTH),
        .DW    (WORD_W)
    ) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    svseq_branch u_branch (
        .pc          (st_q.pc),
        .tgt         (st_q.tgt),
        .cnd         (st_q.cnd),
        .tick        (st_q.running && sclk_en),
        .cnt_last    (st_q.cnt == CNT_W'(1)),
        .sync_found  (sync_found),
        .hsw_pend    (st_q.hsw || hsw_req),
        .ext_event   (ext_event),
        .load        (br_load),
        .nxt_pc      (br_nxt),
        .hsw_consume (br_consume)
    );

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = SEQ_IDLE;
        end else if (!st_q.running) begin
            if (sclk_en) begin
                st_d.running = 1'b1;
                st_d.pc      = '0;
                st_d.cnt     = hold_len(rd_cmd.hold);
                st_d.tgt     = rd_cmd.tgt;
                st_d.cnd     = rd_cmd.cnd;
                st_d.gate    = rd_cmd.act[ACT_GATE_BIT];
                st_d.acq     = rd_cmd.act[ACT_ACQ_BIT];
                st_d.irq     = rd_cmd.act[ACT_IRQ_BIT];
                st_d.hsw     = 1'b0;
            end
        end else begin
            st_d.hsw = (st_q.hsw || hsw_req) && !br_consume;
            if (br_load) begin
                st_d.pc   = br_nxt;
                st_d.cnt  = hold_len(rd_cmd.hold);
                st_d.tgt  = rd_cmd.tgt;
                st_d.cnd  = rd_cmd.cnd;
                st_d.gate = rd_cmd.act[ACT_GATE_BIT];
                st_d.acq  = rd_cmd.act[ACT_ACQ_BIT];
                st_d.irq  = rd_cmd.act[ACT_IRQ_BIT];
            end else if (sclk_en) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o    = st_q.gate;
    assign acq_o     = st_q.acq;
    assign irq_o     = st_q.irq;
    assign addr_o    = st_q.pc;

    assign running_w = st_q.running;
    assign cnt_w     = st_q.cnt;
    assign cond_w    = st_q.cnd;
    assign tgt_w     = st_q.tgt;

endmodule

// File: rtl/svseq_chk.sv
module svseq_chk
    import svseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              sclk_en,
    input logic              sync_found,
    input logic              gate_o,
    input logic              acq_o,
    input logic              irq_o,
    input logic [SEQ_AW-1:0] addr_o,
    input logic              running_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [CND_W-1:0]  cond_w,
    input logic [SEQ_AW-1:0] tgt_w
);

    // R11
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!gate_o && !acq_o && !irq_o && addr_o == '0));

    // R3
    start_entry0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_w && run && sclk_en) |=> (running_w && addr_o == '0));

    // R4
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sclk_en) |=> ($stable(addr_o) && $stable(gate_o) && $stable(acq_o) && $stable(irq_o)));

    // R5
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_w |-> (cnt_w != '0));

    // R6
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_w && run && sclk_en && cnt_w == CNT_W'(1) && cond_w == CND_NEXT)
        |=> (addr_o == SEQ_AW'($past(addr_o) + SEQ_AW'(1))));

    // R7
    jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_w && run && sclk_en && cnt_w == CNT_W'(1) && cond_w == CND_JUMP)
        |=> (addr_o == $past(tgt_w)));

    // R8
    sync_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_w && run && sclk_en && sync_found && cond_w == CND_SYNC)
        |=> (addr_o == $past(tgt_w)));

endmodule

bind svo_gate_seq svseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sclk_en    (sclk_en),
    .sync_found (sync_found),
    .gate_o     (gate_o),
    .acq_o      (acq_o),
    .irq_o      (irq_o),
    .addr_o     (addr_o),
    .running_w  (running_w),
    .cnt_w      (cnt_w),
    .cond_w     (cond_w),
    .tgt_w      (tgt_w)
);

// File: tb/svo_gate_seq_bench.sv
module svo_gate_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        run = 1'b0;
    logic        sclk_en = 1'b0;
    logic        sync_found = 1'b0;
    logic        hsw_req = 1'b0;
    logic        ext_event = 1'b0;
    logic        gate_o, acq_o, irq_o;
    logic [4:0]  addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    svo_gate_seq u_svo_gate_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run(run), .sclk_en(sclk_en), .sync_found(sync_found), .hsw_req(hsw_req),
        .ext_event(ext_event), .gate_o(gate_o), .acq_o(acq_o), .irq_o(irq_o), .addr_o(addr_o)
    );

    // reference model built from the requirements
    logic [31:0] m_mem [32];
    bit          m_run;
    logic [4:0]  m_pc;
    int          m_cnt;
    logic [31:0] m_word;
    bit          m_hsw;
    bit          m_g, m_a, m_i;

    function automatic int hold_of(input logic [31:0] w);
        return (w[31:16] == 16'd0) ? 1 : int'(w[31:16]);
    endfunction

    task automatic m_load(input logic [4:0] a);
        m_pc   = a;
        m_word = m_mem[a];
        m_cnt  = hold_of(m_word);
        m_g    = m_word[1];
        m_a    = m_word[0];
        m_i    = m_word[4];
        m_run  = 1'b1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pc = 0; m_cnt = 0; m_word = 0; m_hsw = 0;
            m_g = 0; m_a = 0; m_i = 0;
        end else begin
            bit was_run;
            was_run = m_run;
            if (!run) begin
                m_run = 0; m_pc = 0; m_hsw = 0; m_g = 0; m_a = 0; m_i = 0;
            end else if (!m_run) begin
                if (sclk_en) begin
                    m_hsw = 0;
                    m_load(5'd0);
                end
            end else begin
                logic [2:0] c;
                logic [4:0] t;
                bit consumed;
                c = m_word[10:8];
                t = m_word[15:11];
                consumed = 0;
                if (sclk_en) begin
                    if (c == 3'd3 && sync_found) begin
                        m_load(t);
                    end else if (m_cnt == 1) begin
                        bit take;
                        take = (c == 3'd5) || (c == 3'd2 && (m_hsw || hsw_req)) ||
                               (c == 3'd1 && ext_event);
                        if (c == 3'd2) consumed = 1;
                        m_load(take ? t : m_pc + 5'd1);
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end
                m_hsw = consumed ? 1'b0 : (m_hsw || hsw_req);
            end
            if (wr_en && !was_run) m_mem[wr_addr] = wr_data;
        end
    end

    task automatic cmp(input string tag);
        n_chk++;
        if (gate_o !== m_g || acq_o !== m_a || irq_o !== m_i || addr_o !== m_pc) begin
            n_bad++;
            $display("FAIL %s: got g%0b a%0b i%0b addr%0d, expected g%0b a%0b i%0b addr%0d",
                     tag, gate_o, acq_o, irq_o, addr_o, m_g, m_a, m_i, m_pc);
        end
    endtask

    task automatic expect_out(input string tag, input bit g, input bit a, input bit i,
                              input logic [4:0] pc);
        n_chk++;
        if (gate_o !== g || acq_o !== a || irq_o !== i || addr_o !== pc) begin
            n_bad++;
            $display("FAIL %s: got g%0b a%0b i%0b addr%0d, expected g%0b a%0b i%0b addr%0d",
                     tag, gate_o, acq_o, irq_o, addr_o, g, a, i, pc);
        end
    endtask

    // one clock: inputs already set at a falling edge, sample at the next falling edge
    task automatic step(input string tag);
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic steps(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    function automatic logic [31:0] mk(input int hold, input int tgt, input int cnd,
                                       input logic [7:0] act);
        return {16'(hold), 5'(tgt), 3'(cnd), act};
    endfunction

    task automatic put(input int a, input logic [31:0] w);
        wr_en = 1; wr_addr = 5'(a); wr_data = w;
        step("R12");
        wr_en = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_out("R1", 0, 0, 0, 5'd0);

        for (int a = 0; a < 32; a++) put(a, mk(1, 0, 4, 8'h00));
        put(0,  mk(3, 0, 4, 8'h23));
        put(1,  mk(0, 0, 4, 8'h22));
        put(2,  mk(5, 6, 3, 8'h22));
        put(3,  mk(2, 0, 5, 8'h20));
        put(6,  mk(2, 8, 2, 8'h12));
        put(7,  mk(1, 0, 5, 8'h00));
        put(8,  mk(2, 31, 1, 8'h10));
        put(9,  mk(1, 0, 5, 8'h01));
        put(31, mk(1, 0, 4, 8'hE3));

        sclk_en = 1; run = 1;
        step("R3");
        expect_out("R3", 1, 1, 0, 5'd0);
        steps(2, "R4");
        expect_out("R4", 1, 1, 0, 5'd0);
        step("R2");
        expect_out("R2", 1, 0, 0, 5'd1);
        step("R5");
        expect_out("R5", 1, 0, 0, 5'd2);
        sclk_en = 0;
        steps(3, "R4");
        expect_out("R4", 1, 0, 0, 5'd2);
        sclk_en = 1;
        steps(4, "R8");
        expect_out("R8", 1, 0, 0, 5'd2);
        step("R8");
        expect_out("R8", 0, 0, 0, 5'd3);
        steps(2, "R7");
        expect_out("R7", 1, 1, 0, 5'd0);
        steps(4, "R6");
        expect_out("R6", 1, 0, 0, 5'd2);
        sync_found = 1;
        step("R8");
        sync_found = 0;
        expect_out("R8", 1, 0, 1, 5'd6);
        hsw_req = 1;
        step("R9");
        hsw_req = 0;
        step("R9");
        expect_out("R9", 0, 0, 1, 5'd8);
        ext_event = 1;
        steps(2, "R10");
        ext_event = 0;
        expect_out("R10", 1, 1, 0, 5'd31);
        step("R6");
        expect_out("R6", 1, 1, 0, 5'd0);
        steps(4, "R8");
        sync_found = 1;
        step("R8");
        sync_found = 0;
        expect_out("R8", 1, 0, 1, 5'd6);
        steps(2, "R9");
        expect_out("R9", 0, 0, 0, 5'd7);
        step("R7");
        expect_out("R7", 1, 1, 0, 5'd0);

        // write attempted while running
        wr_en = 1; wr_addr = 5'd0; wr_data = mk(4, 0, 4, 8'h10);
        step("R12");
        wr_en = 0;
        run = 0;
        step("R11");
        expect_out("R11", 0, 0, 0, 5'd0);
        run = 1;
        step("R12");
        expect_out("R12", 1, 1, 0, 5'd0);
        run = 0;
        step("R11");
        put(0, mk(4, 0, 4, 8'h10));
        run = 1;
        step("R12");
        expect_out("R12", 0, 0, 1, 5'd0);
        run = 0;
        step("R11");

        // random program and random stimulus, compared each cycle to the model
        for (int a = 0; a < 32; a++) begin
            logic [7:0] act;
            act = 8'($urandom) & 8'h13;
            put(a, mk(int'($urandom % 6), int'($urandom % 32), int'($urandom % 8), act));
        end
        run = 1;
        for (int n = 0; n < 5000; n++) begin
            sclk_en    = ($urandom % 10) < 7;
            sync_found = ($urandom % 10) == 0;
            hsw_req    = ($urandom % 20) == 0;
            ext_event  = ($urandom % 3) == 0;
            run        = ($urandom % 150) != 0;
            wr_en      = ($urandom % 25) == 0;
            wr_addr    = 5'($urandom);
            wr_data    = mk(int'($urandom % 6), int'($urandom % 32), int'($urandom % 8),
                            8'($urandom));
            step("R4");
        end
        wr_en = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule